// File: doc/BRIEF.md
# Retired-Store Commit Queue with Line Overlap Gate

This block sits between the store execution stage and the data cache write port. A store that has executed hands its address and data to the queue and can leave the pipeline straight away. The queue then writes its entries into the cache one at a time, oldest first. Writing an entry into the cache is the point at which other cores can see it.

The oldest entry is not made to wait for older loads that missed in the cache. Instead, its cache-line address is compared against every valid slot of the pending load-miss tracker, which the block sees only through ports. If no pending miss is on the same 64-byte line, the store goes to the cache at once, even while those older loads are still waiting for their fills. This is the mechanism that lets a later store become visible before an earlier load has returned its data. If a pending miss is on the same line, the store waits until the tracker drops that slot, which it does when the fill has completed. A pipeline flush does not touch the queue, because retired stores can no longer be rolled back. An empty flag lets a memory barrier wait for the queue to drain.

Top module: `store_commit_queue`

## Requirements
- R1: After reset the queue is empty: `empty` is 1, `cacheWrReq` is 0 and `stReady` is 1.
- R2: A store is taken in on a rising edge where `stValid` and `stReady` are both 1. From the next cycle the queue holds one more entry.
- R3: Entries are offered to the cache in the order they were taken in. `cacheWrAddr` and `cacheWrData` always show the oldest entry.
- R4: When the oldest entry's line matches no valid pending load, `cacheWrReq` is 1 in the cycle after that entry is taken in. This holds even when loads to other lines are pending.
- R5: The line of an address is bits [ADDR_W-1:6]. Bits [5:0] play no part in the comparison. While any valid pending load is on the oldest entry's line, `cacheWrReq` is 0.
- R6: A pending-load slot whose valid bit is 0 never blocks a store, whatever address it carries.
- R7: An entry leaves the queue only on an edge where `cacheWrReq` and `cacheWrGnt` are both 1, and at most one entry leaves per cycle. Without a grant, the oldest entry and its outputs stay unchanged.
- R8: With DEPTH (8) entries held, `stReady` is 0. A `stValid` pulse in that state adds no entry.
- R9: `flush` removes no entry. Every store held before a flush is still written to the cache afterwards, in order.
- R10: `empty` is 1 exactly when no entry is held. While it is 1, `cacheWrReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush or rollback; leaves the queue untouched |
| stValid | input | 1 | A retired store is offered |
| stAddr | input | ADDR_W | Byte address of the offered store |
| stData | input | DATA_W | Data of the offered store |
| stReady | output | 1 | Queue has a free entry |
| ldPendValid | input | NLD | Valid bit of each pending load-miss slot |
| ldPendAddr | input | NLD*ADDR_W | Address of each pending load-miss slot, slot 0 in the low bits |
| cacheWrReq | output | 1 | Oldest entry may be written now |
| cacheWrAddr | output | ADDR_W | Address of the oldest entry |
| cacheWrData | output | DATA_W | Data of the oldest entry |
| cacheWrGnt | input | 1 | Cache write port accepts the request this cycle |
| empty | output | 1 | No store held, for barrier use |

## Verification
The overlap gate is swept over store byte offsets spread across a whole line. The blocking load is moved through every tracker slot, its own offset is mirrored against the store's, and the other slots hold loads to nearby lines. This separates a true line-granular compare from a compare that uses the full address or checks only one slot. After each block, clearing the valid bit of the matching slot must release the store. This shows that invalid slots are ignored and that commit follows the fill rather than load order. Separate sequences drain a queue filled to capacity with the grant withheld and then given, and drain a queue after a flush. These expose lost, duplicated or reordered entries, as well as an overflow write while the queue is full.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } scb_strobe_t;
endpackage

// File: rtl/scb_ctrl.sv
module scb_ctrl
  import scb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             stValid,
  input  logic             cacheWrGnt,
  input  logic             headBlocked,
  output logic             stReady,
  output logic             empty,
  output logic             cacheWrReq,
  output scb_strobe_t      strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr
);
  logic [CNT_W-1:0] count;
  logic             full;

  assign full       = (count == CNT_W'(DEPTH));
  assign empty      = (count == '0);
  assign stReady    = !full;
  assign cacheWrReq = !empty && !headBlocked;

  always_comb begin
    strobe.push = stValid && !full;
    strobe.pop  = cacheWrReq && cacheWrGnt;
  end

  // flush is deliberately not an input of this state: retired stores stay.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady && !strobe.pop) |=> (count == $past(count) + 1'b1));

  p_flush_keeps_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !stValid && !cacheWrGnt) |=> (count == $past(count)));

  p_empty_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !cacheWrReq);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stReady && !cacheWrGnt) |=> !stReady);
endmodule

// File: rtl/scb_data.sv
module scb_data
  import scb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NLD       = 4,
  parameter int LINE_BITS = 6,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LINE_W = ADDR_W - LINE_BITS
) (
  input  logic                  clk,
  input  scb_strobe_t           strobe,
  input  logic [PTR_W-1:0]      wrPtr,
  input  logic [PTR_W-1:0]      rdPtr,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [DATA_W-1:0]     stData,
  input  logic [NLD-1:0]        ldPendValid,
  input  logic [NLD*ADDR_W-1:0] ldPendAddr,
  output logic [ADDR_W-1:0]     headAddr,
  output logic [DATA_W-1:0]     headData,
  output logic                  headBlocked
);
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [NLD-1:0]    lineHit;

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      addrMem[wrPtr] <= stAddr;
      dataMem[wrPtr] <= stData;
    end
  end

  assign headAddr = addrMem[rdPtr];
  assign headData = dataMem[rdPtr];

  for (genvar g = 0; g < NLD; g++) begin : g_probe
    logic [ADDR_W-1:0] slotAddr;
    assign slotAddr   = ldPendAddr[g*ADDR_W +: ADDR_W];
    assign lineHit[g] = ldPendValid[g] &&
      (slotAddr[ADDR_W-1 -: LINE_W] == headAddr[ADDR_W-1 -: LINE_W]);
  end

  assign headBlocked = |lineHit;
endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue
  import scb_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NLD       = 4,
  parameter int LINE_BITS = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic                  stValid,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [DATA_W-1:0]     stData,
  output logic                  stReady,
  input  logic [NLD-1:0]        ldPendValid,
  input  logic [NLD*ADDR_W-1:0] ldPendAddr,
  output logic                  cacheWrReq,
  output logic [ADDR_W-1:0]     cacheWrAddr,
  output logic [DATA_W-1:0]     cacheWrData,
  input  logic                  cacheWrGnt,
  output logic                  empty
);
  scb_strobe_t      strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             headBlocked;

  scb_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .stValid(stValid),
    .cacheWrGnt(cacheWrGnt), .headBlocked(headBlocked), .stReady(stReady),
    .empty(empty), .cacheWrReq(cacheWrReq), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  scb_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NLD(NLD),
             .LINE_BITS(LINE_BITS)) i_data (
    .clk(clk), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .stAddr(stAddr), .stData(stData), .ldPendValid(ldPendValid),
    .ldPendAddr(ldPendAddr), .headAddr(cacheWrAddr), .headData(cacheWrData),
    .headBlocked(headBlocked)
  );

  function automatic logic portLineMatch(input logic [NLD-1:0] v,
                                         input logic [NLD*ADDR_W-1:0] a,
                                         input logic [ADDR_W-1:0] s);
    logic m;
    m = 1'b0;
    for (int i = 0; i < NLD; i++)
      if (v[i] && ((a[i*ADDR_W +: ADDR_W] >> LINE_BITS) == (s >> LINE_BITS)))
        m = 1'b1;
    return m;
  endfunction

  p_hold_ungranted_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cacheWrReq && !cacheWrGnt && !empty) |=>
      ($stable(cacheWrAddr) && $stable(cacheWrData)));

  p_gate_overlap_r5: assert property (@(posedge clk) disable iff (!rstN)
    cacheWrReq |-> !portLineMatch(ldPendValid, ldPendAddr, cacheWrAddr));
endmodule

// File: tb/test_store_commit_queue.sv
`timescale 1ns/1ps
module test_store_commit_queue;
  localparam int ADDR_W = 32, DATA_W = 32, NLD = 4, DEPTH = 8;

  logic clk = 0, rstN = 0, flush = 0, stValid = 0, cacheWrGnt = 0;
  logic [ADDR_W-1:0] stAddr = '0;
  logic [DATA_W-1:0] stData = '0;
  logic [NLD-1:0] ldPendValid = '0;
  logic [NLD*ADDR_W-1:0] ldPendAddr = '0;
  logic stReady, cacheWrReq, empty;
  logic [ADDR_W-1:0] cacheWrAddr;
  logic [DATA_W-1:0] cacheWrData;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  store_commit_queue i_store_commit_queue (
    .clk(clk), .rstN(rstN), .flush(flush), .stValid(stValid), .stAddr(stAddr),
    .stData(stData), .stReady(stReady), .ldPendValid(ldPendValid),
    .ldPendAddr(ldPendAddr), .cacheWrReq(cacheWrReq), .cacheWrAddr(cacheWrAddr),
    .cacheWrData(cacheWrData), .cacheWrGnt(cacheWrGnt), .empty(empty)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    stValid = 1; stAddr = a; stData = d;
    @(negedge clk);
    stValid = 0;
  endtask

  task automatic drainOne(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cacheWrGnt = 1;
    check({req, " req"}, cacheWrReq, 1);
    check({req, " addr"}, cacheWrAddr, a);
    check({req, " data"}, cacheWrData, d);
    @(negedge clk);
    cacheWrGnt = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 and R10: reset state
    check("R1 empty", empty, 1);
    check("R1 req", cacheWrReq, 0);
    check("R1 ready", stReady, 1);
    rstN = 1;
    @(negedge clk);

    // R2, R3, R4, R7: three stores, loads pending to unrelated lines
    for (int j = 0; j < NLD; j++) ldPendAddr[j*ADDR_W +: ADDR_W] = 32'h9000_0000 + j * 64;
    ldPendValid = '1;
    push(32'h1000_0004, 32'hA0); 
    check("R4 req with other lines pending", cacheWrReq, 1);
    check("R2 not empty", empty, 0);
    push(32'h2000_0008, 32'hA1);
    push(32'h3000_000C, 32'hA2);
    repeat (3) @(negedge clk);
    check("R7 held addr", cacheWrAddr, 32'h1000_0004);
    check("R7 held data", cacheWrData, 32'hA0);
    drainOne("R3 first", 32'h1000_0004, 32'hA0);
    drainOne("R3 second", 32'h2000_0008, 32'hA1);
    drainOne("R3 third", 32'h3000_000C, 32'hA2);
    check("R10 empty after drain", empty, 1);
    check("R10 no req when empty", cacheWrReq, 0);
    ldPendValid = '0;

    // R5, R6: line overlap sweep over offsets and slots
    for (int off = 0; off < 64; off += 9) begin
      automatic int k = off % NLD;
      automatic logic [25:0] line = 26'h12340 + 26'(off);
      for (int j = 0; j < NLD; j++)
        ldPendAddr[j*ADDR_W +: ADDR_W] = {line + 26'(j) + 26'd1, 6'd0};
      ldPendAddr[k*ADDR_W +: ADDR_W] = {line, 6'(63 - off)};
      ldPendValid = '1;
      push({line, 6'(off)}, 32'(off) + 32'h55);
      check("R5 blocked by same line", cacheWrReq, 0);
      @(negedge clk);
      check("R5 still blocked", cacheWrReq, 0);
      ldPendValid[k] = 1'b0;
      #1;
      check("R6 invalid slot ignored", cacheWrReq, 1);
      drainOne("R5 released", {line, 6'(off)}, 32'(off) + 32'h55);
      ldPendValid = '0;
    end

    // R8: fill to capacity, try an extra push, drain all
    for (int i = 0; i < DEPTH; i++) push(32'h4000_0000 + i * 128, 32'hC0 + i);
    check("R8 ready low when full", stReady, 0);
    push(32'hDEAD_0000, 32'hBAD);
    for (int i = 0; i < DEPTH; i++)
      drainOne("R8 drain", 32'h4000_0000 + i * 128, 32'hC0 + i);
    check("R8 no extra entry", empty, 1);
    check("R8 ready again", stReady, 1);

    // R9: flush keeps stores
    push(32'h5000_0010, 32'hD0);
    push(32'h5000_0050, 32'hD1);
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    check("R9 not empty after flush", empty, 0);
    drainOne("R9 first", 32'h5000_0010, 32'hD0);
    drainOne("R9 second", 32'h5000_0050, 32'hD1);
    check("R9 empty", empty, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule